// File: doc/BRIEF.md
# Write-Once Memory Timing Tick Divider

This block derives the slow timing reference that a nonvolatile memory program/erase engine needs from the bus clock. It holds a single 8-bit configuration register on a simple register bus: a write strobe, write data and combinational read data. The configuration can be written once after reset. A flag in the register shows that this write has happened, and the same flag drives an enable output that permits program/erase activity.

The divider chain has two stages. The first is a fixed divide-by-8 prescaler that the configuration can switch in or leave out. The second is a programmable counter that divides by the 6-bit divisor plus one. Both stages work as clock enables in the bus clock domain. The block emits a one-bus-cycle tick at the end of every divided period. Software chooses the divisor so that the tick period falls between about 5 and 6.7 microseconds, which is 150 to 200 kHz.

Top module: `nvm_tick_gen`

## Requirements
- R1: After reset, reg_rdata reads 0x00, pe_enable is low and tick stays low.
- R2: The first write after reset sets reg_rdata[7] to 1 whatever data is written, and it stores reg_wdata[6:0] into reg_rdata[6:0] (bit 6 = prescale on, bits 5:0 = divisor N).
- R3: Once reg_rdata[7] is 1, every further write is ignored: reg_rdata and the tick period stay unchanged until the next reset.
- R4: The value written to bit 7 has no effect. Bit 7 always reads back the current loaded flag.
- R5: pe_enable equals the loaded flag (reg_rdata[7]) in every cycle.
- R6: tick never rises while the loaded flag is 0.
- R7: With prescale off, tick is high in the (N+1)-th bus cycle after the write's clock edge, and after that every N+1 cycles. With N = 0, tick is high in every cycle.
- R8: With prescale on, tick is high in the 8·(N+1)-th bus cycle after the write's clock edge, and after that every 8·(N+1) cycles. Each tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data {loaded, prescale, divisor} |
| pe_enable | output | 1 | Program/erase permitted |
| tick | output | 1 | One-cycle pulse per divided period |

## Verification
The bench puts the phase of the first tick under test as well as the spacing between ticks. A design that let its counters run before the write, or that started them a cycle late, would produce the first tick at the wrong cycle even if the spacing were correct. The bench covers the smallest divisor with and without the prescaler, and the largest divisor. An off-by-one in the compare would shift every period, and a prescaler that is not properly bypassed would slow the N = 0 case to one tick every 8 cycles. The bench also makes a second write, with different data, in the middle of a run. A register that did not lock would then show the new value on the read port and change the period. The bench also writes 0x00 and 0x80 as the first data, which exposes a flag that follows the data bit instead of the write event.

// File: rtl/nvm_tick_pkg.sv
package nvm_tick_pkg;
   typedef enum logic {
      PS_BYPASS = 1'b0,
      PS_DIVIDE = 1'b1
   } ps_mode_e;

   function automatic int unsigned ratio_width(input int unsigned ratio);
      return (ratio > 2) ? $clog2(ratio) : 1;
   endfunction
endpackage

// File: rtl/nvm_tick_cfg.sv
module nvm_tick_cfg #(
   parameter int DIV_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [DIV_W+1:0]   wdata,
   output logic               loaded,
   output nvm_tick_pkg::ps_mode_e ps_mode,
   output logic [DIV_W-1:0]   divisor,
   output logic [DIV_W+1:0]   rdata
);
   import nvm_tick_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loaded  <= 1'b0;
         ps_mode <= PS_BYPASS;
         divisor <= '0;
      end else if (wr && !loaded) begin
         loaded  <= 1'b1;
         ps_mode <= ps_mode_e'(wdata[DIV_W]);
         divisor <= wdata[DIV_W-1:0];
      end
   end

   assign rdata = {loaded, ps_mode, divisor};

   logic unused_msb;
   assign unused_msb = wdata[DIV_W+1];
endmodule

// File: rtl/nvm_tick_prescale.sv
module nvm_tick_prescale #(
   parameter int PRE_RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  nvm_tick_pkg::ps_mode_e ps_mode,
   output logic step
);
   import nvm_tick_pkg::*;
   localparam int PRE_W = ratio_width(PRE_RATIO);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

   generate
      if (PRE_RATIO > 1) begin : g_counter
         logic [PRE_W-1:0] pcnt;
         logic             wrap;
         assign wrap = (pcnt == PRE_LAST);

         always_ff @(posedge clk) begin
            if (!rst_n || !run || ps_mode == PS_BYPASS) begin
               pcnt <= '0;
            end else if (wrap) begin
               pcnt <= '0;
            end else begin
               pcnt <= pcnt + 1'b1;
            end
         end

         assign step = run && ((ps_mode == PS_BYPASS) || wrap);
      end else begin : g_bypass
         logic unused_mode;
         assign unused_mode = ps_mode[0] ^ clk ^ rst_n;
         assign step = run;
      end
   endgenerate
endmodule

// File: rtl/nvm_tick_divcnt.sv
module nvm_tick_divcnt #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= at_end ? '0 : cnt + 1'b1;
      end
   end

   assign tick = run && step && at_end;
endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
   parameter int DATA_W    = 8,
   parameter int DIV_W     = 6,
   parameter int PRE_RATIO = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              pe_enable,
   output logic              tick
);
   import nvm_tick_pkg::*;

   generate
      if (DATA_W != DIV_W + 2) begin : g_bad_width
         $error("nvm_tick_gen: DATA_W must equal DIV_W + 2");
      end
      if (PRE_RATIO < 1) begin : g_bad_ratio
         $error("nvm_tick_gen: PRE_RATIO must be at least 1");
      end
   endgenerate

   logic             loaded;
   ps_mode_e         ps_mode;
   logic [DIV_W-1:0] divisor;
   logic             step;

   nvm_tick_cfg #(.DIV_W(DIV_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .loaded(loaded), .ps_mode(ps_mode), .divisor(divisor), .rdata(reg_rdata)
   );

   nvm_tick_prescale #(.PRE_RATIO(PRE_RATIO)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(loaded), .ps_mode(ps_mode), .step(step)
   );

   nvm_tick_divcnt #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(loaded), .step(step),
      .limit(divisor), .tick(tick)
   );

   assign pe_enable = loaded;
endmodule

// File: rtl/nvm_tick_gen_chk.sv
module nvm_tick_gen_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              pe_enable,
   input logic              tick
);
   assert_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pe_enable == reg_rdata[DATA_W-1]);

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[DATA_W-1] |-> !tick);

   assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rdata[DATA_W-1]) |=> reg_rdata[DATA_W-1]);

   assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1] |=> $stable(reg_rdata));

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && reg_rdata[DATA_W-2]) |=> !tick);
endmodule

bind nvm_tick_gen nvm_tick_gen_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
   .pe_enable(pe_enable), .tick(tick)
);

// File: tb/nvm_tick_gen_test.sv
module nvm_tick_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       pe_enable;
   logic       tick;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   int exp_q[$];

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   nvm_tick_gen uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pe_enable(pe_enable), .tick(tick)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops expected tick cycles (R6, R7, R8)
   always @(negedge clk) begin
      if (mon_on && tick) begin
         if (exp_q.size() == 0) begin
            check("R6/R7/R8 unexpected tick", cyc, -1);
         end else begin
            check("R7/R8 tick cycle", cyc, exp_q.pop_front());
            if (exp_q.size() == 0) mon_on = 1'b0;
         end
      end
   end

   task automatic run_case(input logic [7:0] wd, input logic [7:0] exp_rd,
                           input int period, input int n_ticks,
                           input bit second, input logic [7:0] wd2);
      int w;
      int last;
      rst_n  = 1'b0;
      reg_wr = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 rdata after reset", reg_rdata, 8'h00);
      check("R1 pe_enable after reset", pe_enable, 0);
      rst_n  = 1'b1;
      mon_on = 1'b1;
      repeat (4) @(negedge clk);
      check("R5 pe_enable before write", pe_enable, 0);
      w = cyc + 1;
      for (int j = 0; j < n_ticks; j++) exp_q.push_back(w + period - 1 + j * period);
      last = w + period - 1 + (n_ticks - 1) * period;
      reg_wr    = 1'b1;
      reg_wdata = wd;
      @(negedge clk);
      reg_wr = 1'b0;
      check("R2/R4 rdata after first write", reg_rdata, exp_rd);
      check("R5 pe_enable after write", pe_enable, 1);
      if (second) begin
         reg_wr    = 1'b1;
         reg_wdata = wd2;
         @(negedge clk);
         reg_wr = 1'b0;
         @(negedge clk);
         check("R3 rdata after second write", reg_rdata, exp_rd);
      end
      while (cyc <= last + 1) @(negedge clk);
      check("R7/R8 all ticks seen", exp_q.size(), 0);
      exp_q.delete();
      mon_on = 1'b0;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      run_case(8'h00, 8'h80, 1, 4, 1'b0, 8'h00);   // R2 any data, R7 N=0
      run_case(8'h05, 8'h85, 6, 4, 1'b1, 8'h4A);   // R3 lock, R7
      run_case(8'h40, 8'hC0, 8, 3, 1'b0, 8'h00);   // R8 N=0 prescale
      run_case(8'h43, 8'hC3, 32, 3, 1'b1, 8'h00);  // R8, R3
      run_case(8'h80, 8'h80, 1, 3, 1'b1, 8'h3F);   // R4 bit7 ignored
      run_case(8'h3F, 8'hBF, 64, 2, 1'b0, 8'h00);  // R7 max divisor
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule